// File: doc/BRIEF.md
# Variable-Length Instruction Format Decoder

This block takes one 16-bit instruction word and turns it into the fields that a downstream execute stage needs. It reports the encoding form, an operation class and an ALU function code, the memory access size, two 4-bit register numbers, an 8-bit immediate, a branch condition with a byte offset, and an illegal flag. It also reports the instruction length in bytes. A length of 6 tells the fetch unit that a 32-bit word follows the opcode. The block neither fetches that word nor executes anything.

The decode is combinational, and one register stage follows it. A word presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. The two top bits of the word select one of three forms. A clear bit 15 selects the primary form, whose opcode is bits 15:8. Bits 15:14 equal to 2'b10 select the immediate form. Bits 15:14 equal to 2'b11 select the conditional-branch form.

Top module: `insn_fmt_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. All other outputs are loaded only from a word that arrives with `in_valid` high, and they hold their values while `in_valid` is low.
- R3: `form` is 0 when bit 15 is clear. It is 1 when bits 15:14 are 2'b10, and 2 when bits 15:14 are 2'b11.
- R4: In the primary form, `reg_a` is bits 7:4 and `reg_b` is bits 3:0. `imm8`, `br_off` and `cond` are zero in this form. Register fields are reported even when the word is illegal.
- R5: In the immediate form, bits 13:12 select the class: 0 is increment (op 13, func 1), 1 is decrement (op 14, func 2), 2 is special-register read (op 15) and 3 is special-register write (op 16). `reg_a` is bits 11:8, `imm8` is bits 7:0, and `reg_b` is zero. This form is never illegal.
- R6: `len_bytes` is 6 for the primary opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39. Every other word reports 2.
- R7: A primary opcode is legal if it lies in 0x00 to 0x0E or in 0x19 to 0x39. Any other primary opcode sets `illegal`.
- R8: An illegal word reports op 0, func 0, mem_size 0, len 2 and `wr_en` low.
- R9: Primary op classes are as follows. NOP=0 (0x00), LDI=1 (0x01, 0x1B, 0x20), MOV=2 (0x02), CALL=3 (0x03, 0x19), RET=4 (0x04), ALU=5, PUSH=6 (0x06), POP=7 (0x07). LOAD=8 covers 0x08, 0x0A, 0x0C, 0x1C, 0x1D, 0x21, 0x22, 0x36 and 0x38. STORE=9 covers 0x09, 0x0B, 0x0D, 0x1E, 0x1F, 0x23, 0x24, 0x37 and 0x39. CMP=10 (0x0E), JUMP=11 (0x1A, 0x25), TRAP=12 (0x30, 0x35).
- R10: ALU-class func codes are as follows: ADD=1 (0x05), SUB=2 (0x29), AND=3 (0x26), OR=4 (0x2B), XOR=5 (0x2E), SHL=6 (0x28), SHR=7 (0x27), SAR=8 (0x2D), NEG=9 (0x2A), NOT=10 (0x2C), MUL=11 (0x2F), DIV=12 (0x31), UDIV=13 (0x32), MOD=14 (0x33), UMOD=15 (0x34). The three shift codes mark operations whose amount the execute stage takes from the low 5 bits of the amount register. Every other class reports func 0, except increment and decrement (see R5).
- R11: `mem_size` is 0 for a word access. It is 1 for a byte access (0x1B to 0x1F, 0x36, 0x37) and 2 for a half-word access (0x20 to 0x24, 0x38, 0x39). Every other operation reports 0.
- R12: `wr_en` is high exactly for op classes LDI, MOV, ALU, LOAD, POP, increment, decrement and special-register read.
- R13: In the branch form, `cond` is bits 13:10. It is legal for values 0 to 9 (op 17) and illegal above 9. `br_off` is the 11-bit two's-complement value of bits 9:0 times two. `reg_a`, `reg_b` and `imm8` are zero in this form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| insn | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields valid |
| form | output | 2 | Encoding form (0 primary, 1 immediate, 2 branch) |
| op | output | 5 | Operation class |
| func | output | 4 | ALU function code |
| mem_size | output | 2 | Access size (0 word, 1 byte, 2 half) |
| reg_a | output | 4 | First register field |
| reg_b | output | 4 | Second register field |
| imm8 | output | 8 | Short unsigned immediate |
| br_off | output | 11 | Branch byte offset, two's complement |
| cond | output | 4 | Branch condition number |
| len_bytes | output | 3 | Instruction length in bytes (2 or 6) |
| illegal | output | 1 | Undefined encoding |
| wr_en | output | 1 | A general register is written |

## Verification
Some rules are checked by properties on every cycle. These are the one-cycle valid pipeline and the holding of fields while idle, and the choice of form from the top two bits. They also cover the squashing of illegal words to a harmless no-op, the restriction of the 6-byte length to legal primary words, and the condition range in the branch form. The exact opcode-to-class, function, size and length maps can only be shown by the bench's scenarios. These include a sweep over every primary opcode and a vector table. Branch offsets at both extremes and the reset values are likewise shown only by directed cases.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int INSN_W    = 16;
  localparam int LOW_W     = 14;
  localparam int RF_W      = 4;
  localparam int IMM_W     = 8;
  localparam int OFF_FLD_W = 10;
  localparam int OFF_W     = OFF_FLD_W + 1;
  localparam int COND_W    = 4;
  localparam int OPC_W     = 8;
  localparam int LEN_W     = 3;
  localparam int COND_LAST = 9;
  localparam logic [LEN_W-1:0] SHORT_LEN = 3'd2;
  localparam logic [LEN_W-1:0] LONG_LEN  = 3'd6;

  typedef enum logic [1:0] {
    FORM_PRIM = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_BR   = 2'd2
  } form_e;

  typedef enum logic [4:0] {
    CLS_NOP    = 5'd0,
    CLS_LDI    = 5'd1,
    CLS_MOV    = 5'd2,
    CLS_CALL   = 5'd3,
    CLS_RET    = 5'd4,
    CLS_ALU    = 5'd5,
    CLS_PUSH   = 5'd6,
    CLS_POP    = 5'd7,
    CLS_LOAD   = 5'd8,
    CLS_STORE  = 5'd9,
    CLS_CMP    = 5'd10,
    CLS_JUMP   = 5'd11,
    CLS_TRAP   = 5'd12,
    CLS_INC    = 5'd13,
    CLS_DEC    = 5'd14,
    CLS_SRD    = 5'd15,
    CLS_SWR    = 5'd16,
    CLS_BRANCH = 5'd17
  } opcls_e;

  typedef enum logic [3:0] {
    FN_NONE = 4'd0,  FN_ADD = 4'd1,  FN_SUB  = 4'd2,  FN_AND = 4'd3,
    FN_OR   = 4'd4,  FN_XOR = 4'd5,  FN_SHL  = 4'd6,  FN_SHR = 4'd7,
    FN_SAR  = 4'd8,  FN_NEG = 4'd9,  FN_NOT  = 4'd10, FN_MUL = 4'd11,
    FN_DIV  = 4'd12, FN_UDIV = 4'd13, FN_MOD = 4'd14, FN_UMOD = 4'd15
  } fn_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2
  } size_e;

  typedef struct packed {
    opcls_e cls;
    fn_e    fn;
    size_e  sz;
    logic   ext;
    logic   ok;
  } prim_info_t;

  typedef struct packed {
    form_e               form;
    opcls_e              cls;
    fn_e                 fn;
    size_e               sz;
    logic [RF_W-1:0]     ra;
    logic [RF_W-1:0]     rb;
    logic [IMM_W-1:0]    imm;
    logic [OFF_W-1:0]    boff;
    logic [COND_W-1:0]   cond;
    logic                ext;
    logic                bad;
  } dec_t;

  // Primary opcode table: class, function, size, trailing word, legality.
  function automatic prim_info_t prim_lookup(input logic [OPC_W-1:0] code);
    prim_info_t r;
    r = '{CLS_NOP, FN_NONE, SZ_WORD, 1'b0, 1'b0};
    case (code)
      8'h00: r = '{CLS_NOP,   FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h01: r = '{CLS_LDI,   FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h02: r = '{CLS_MOV,   FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h03: r = '{CLS_CALL,  FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h04: r = '{CLS_RET,   FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h05: r = '{CLS_ALU,   FN_ADD,  SZ_WORD, 1'b0, 1'b1};
      8'h06: r = '{CLS_PUSH,  FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h07: r = '{CLS_POP,   FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h08: r = '{CLS_LOAD,  FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h09: r = '{CLS_STORE, FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h0A: r = '{CLS_LOAD,  FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h0B: r = '{CLS_STORE, FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h0C: r = '{CLS_LOAD,  FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h0D: r = '{CLS_STORE, FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h0E: r = '{CLS_CMP,   FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h19: r = '{CLS_CALL,  FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h1A: r = '{CLS_JUMP,  FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h1B: r = '{CLS_LDI,   FN_NONE, SZ_BYTE, 1'b1, 1'b1};
      8'h1C: r = '{CLS_LOAD,  FN_NONE, SZ_BYTE, 1'b0, 1'b1};
      8'h1D: r = '{CLS_LOAD,  FN_NONE, SZ_BYTE, 1'b1, 1'b1};
      8'h1E: r = '{CLS_STORE, FN_NONE, SZ_BYTE, 1'b0, 1'b1};
      8'h1F: r = '{CLS_STORE, FN_NONE, SZ_BYTE, 1'b1, 1'b1};
      8'h20: r = '{CLS_LDI,   FN_NONE, SZ_HALF, 1'b1, 1'b1};
      8'h21: r = '{CLS_LOAD,  FN_NONE, SZ_HALF, 1'b0, 1'b1};
      8'h22: r = '{CLS_LOAD,  FN_NONE, SZ_HALF, 1'b1, 1'b1};
      8'h23: r = '{CLS_STORE, FN_NONE, SZ_HALF, 1'b0, 1'b1};
      8'h24: r = '{CLS_STORE, FN_NONE, SZ_HALF, 1'b1, 1'b1};
      8'h25: r = '{CLS_JUMP,  FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h26: r = '{CLS_ALU,   FN_AND,  SZ_WORD, 1'b0, 1'b1};
      8'h27: r = '{CLS_ALU,   FN_SHR,  SZ_WORD, 1'b0, 1'b1};
      8'h28: r = '{CLS_ALU,   FN_SHL,  SZ_WORD, 1'b0, 1'b1};
      8'h29: r = '{CLS_ALU,   FN_SUB,  SZ_WORD, 1'b0, 1'b1};
      8'h2A: r = '{CLS_ALU,   FN_NEG,  SZ_WORD, 1'b0, 1'b1};
      8'h2B: r = '{CLS_ALU,   FN_OR,   SZ_WORD, 1'b0, 1'b1};
      8'h2C: r = '{CLS_ALU,   FN_NOT,  SZ_WORD, 1'b0, 1'b1};
      8'h2D: r = '{CLS_ALU,   FN_SAR,  SZ_WORD, 1'b0, 1'b1};
      8'h2E: r = '{CLS_ALU,   FN_XOR,  SZ_WORD, 1'b0, 1'b1};
      8'h2F: r = '{CLS_ALU,   FN_MUL,  SZ_WORD, 1'b0, 1'b1};
      8'h30: r = '{CLS_TRAP,  FN_NONE, SZ_WORD, 1'b1, 1'b1};
      8'h31: r = '{CLS_ALU,   FN_DIV,  SZ_WORD, 1'b0, 1'b1};
      8'h32: r = '{CLS_ALU,   FN_UDIV, SZ_WORD, 1'b0, 1'b1};
      8'h33: r = '{CLS_ALU,   FN_MOD,  SZ_WORD, 1'b0, 1'b1};
      8'h34: r = '{CLS_ALU,   FN_UMOD, SZ_WORD, 1'b0, 1'b1};
      8'h35: r = '{CLS_TRAP,  FN_NONE, SZ_WORD, 1'b0, 1'b1};
      8'h36: r = '{CLS_LOAD,  FN_NONE, SZ_BYTE, 1'b1, 1'b1};
      8'h37: r = '{CLS_STORE, FN_NONE, SZ_BYTE, 1'b1, 1'b1};
      8'h38: r = '{CLS_LOAD,  FN_NONE, SZ_HALF, 1'b1, 1'b1};
      8'h39: r = '{CLS_STORE, FN_NONE, SZ_HALF, 1'b1, 1'b1};
      default: r = '{CLS_NOP, FN_NONE, SZ_WORD, 1'b0, 1'b0};
    endcase
    return r;
  endfunction

  // Signed 10-bit halfword count -> signed 11-bit byte offset.
  function automatic logic [OFF_W-1:0] branch_offset(input logic [OFF_FLD_W-1:0] f);
    return {f, 1'b0};
  endfunction

  function automatic logic writes_reg(input opcls_e c);
    case (c)
      CLS_LDI, CLS_MOV, CLS_ALU, CLS_LOAD, CLS_POP,
      CLS_INC, CLS_DEC, CLS_SRD: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ifd_prim_dec.sv
module ifd_prim_dec
  import ifd_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  prim_info_t info;

  always_comb begin
    info       = prim_lookup(word[INSN_W-1 -: OPC_W]);
    dec        = '0;
    dec.form   = FORM_PRIM;
    dec.cls    = info.cls;
    dec.fn     = info.fn;
    dec.sz     = info.sz;
    dec.ra     = word[2*RF_W-1:RF_W];
    dec.rb     = word[RF_W-1:0];
    dec.ext    = info.ext;
    dec.bad    = ~info.ok;
  end
endmodule

// File: rtl/ifd_imm_dec.sv
module ifd_imm_dec
  import ifd_pkg::*;
(
  input  logic [LOW_W-1:0] word,
  output dec_t             dec
);
  always_comb begin
    dec      = '0;
    dec.form = FORM_IMM;
    dec.ra   = word[IMM_W+RF_W-1:IMM_W];
    dec.imm  = word[IMM_W-1:0];
    unique case (word[LOW_W-1:LOW_W-2])
      2'd0: begin dec.cls = CLS_INC; dec.fn = FN_ADD; end
      2'd1: begin dec.cls = CLS_DEC; dec.fn = FN_SUB; end
      2'd2: dec.cls = CLS_SRD;
      default: dec.cls = CLS_SWR;
    endcase
  end
endmodule

// File: rtl/ifd_br_dec.sv
module ifd_br_dec
  import ifd_pkg::*;
(
  input  logic [LOW_W-1:0] word,
  output dec_t             dec
);
  logic [COND_W-1:0] cnum;
  assign cnum = word[LOW_W-1 -: COND_W];

  always_comb begin
    dec      = '0;
    dec.form = FORM_BR;
    dec.cls  = CLS_BRANCH;
    dec.cond = cnum;
    dec.boff = branch_offset(word[OFF_FLD_W-1:0]);
    dec.bad  = (cnum > COND_W'(COND_LAST));
  end
endmodule

// File: rtl/insn_fmt_decoder.sv
module insn_fmt_decoder
  import ifd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [INSN_W-1:0]    insn,
  output logic                 out_valid,
  output logic [1:0]           form,
  output logic [4:0]           op,
  output logic [3:0]           func,
  output logic [1:0]           mem_size,
  output logic [RF_W-1:0]      reg_a,
  output logic [RF_W-1:0]      reg_b,
  output logic [IMM_W-1:0]     imm8,
  output logic [OFF_W-1:0]     br_off,
  output logic [COND_W-1:0]    cond,
  output logic [LEN_W-1:0]     len_bytes,
  output logic                 illegal,
  output logic                 wr_en
);
  dec_t  d_prim, d_imm, d_br, d_pick, d_fin;
  form_e sel_form;
  logic  raw_bad;
  logic  wr_c;

  ifd_prim_dec u_prim (.word(insn),              .dec(d_prim));
  ifd_imm_dec  u_imm  (.word(insn[LOW_W-1:0]),   .dec(d_imm));
  ifd_br_dec   u_br   (.word(insn[LOW_W-1:0]),   .dec(d_br));

  // Form select from the two top bits.
  always_comb begin
    if (!insn[INSN_W-1])      sel_form = FORM_PRIM;
    else if (!insn[INSN_W-2]) sel_form = FORM_IMM;
    else                      sel_form = FORM_BR;
  end

  always_comb begin
    unique case (sel_form)
      FORM_PRIM: d_pick = d_prim;
      FORM_IMM:  d_pick = d_imm;
      default:   d_pick = d_br;
    endcase
  end

  assign raw_bad = d_pick.bad;

  // Illegal words collapse to a harmless no-op.
  always_comb begin
    d_fin = d_pick;
    if (raw_bad) begin
      d_fin.cls = CLS_NOP;
      d_fin.fn  = FN_NONE;
      d_fin.sz  = SZ_WORD;
      d_fin.ext = 1'b0;
    end
  end

  assign wr_c = writes_reg(d_fin.cls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      form      <= '0;
      op        <= '0;
      func      <= '0;
      mem_size  <= '0;
      reg_a     <= '0;
      reg_b     <= '0;
      imm8      <= '0;
      br_off    <= '0;
      cond      <= '0;
      len_bytes <= '0;
      illegal   <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        form      <= d_fin.form;
        op        <= d_fin.cls;
        func      <= d_fin.fn;
        mem_size  <= d_fin.sz;
        reg_a     <= d_fin.ra;
        reg_b     <= d_fin.rb;
        imm8      <= d_fin.imm;
        br_off    <= d_fin.boff;
        cond      <= d_fin.cond;
        len_bytes <= d_fin.ext ? LONG_LEN : SHORT_LEN;
        illegal   <= raw_bad;
        wr_en     <= wr_c;
      end
    end
  end
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
  import ifd_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [INSN_W-1:0]    insn,
  input logic                 out_valid,
  input logic [1:0]           form,
  input logic [4:0]           op,
  input logic [3:0]           func,
  input logic [1:0]           mem_size,
  input logic [RF_W-1:0]      reg_a,
  input logic [RF_W-1:0]      reg_b,
  input logic [IMM_W-1:0]     imm8,
  input logic [OFF_W-1:0]     br_off,
  input logic [COND_W-1:0]    cond,
  input logic [LEN_W-1:0]     len_bytes,
  input logic                 illegal,
  input logic                 wr_en,
  input form_e                sel_form,
  input logic                 raw_bad
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |->
      ($stable(op) && $stable(reg_a) && $stable(reg_b) && $stable(imm8) && $stable(len_bytes)));

  // R3
  form_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid)) |->
      (form == ($past(insn[15]) ? ($past(insn[14]) ? 2'd2 : 2'd1) : 2'd0)));

  // R3
  form_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (form == 2'($past(sel_form)) && illegal == $past(raw_bad)));

  // R8
  illegal_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |->
      (op == 5'd0 && func == 4'd0 && mem_size == 2'd0 && len_bytes == 3'd2 && !wr_en));

  // R6
  len_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((len_bytes == 3'd2) || (len_bytes == 3'd6 && form == 2'd0 && !illegal)));

  // R5
  imm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && form == 2'd1) |-> (reg_b == '0 && br_off == '0 && !illegal && op >= 5'd13 && op <= 5'd16));

  // R4
  prim_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && form == 2'd0) |-> (imm8 == '0 && br_off == '0 && cond == '0));

  // R13
  branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && form == 2'd2) |->
      (illegal ? (cond > 4'd9) : (cond <= 4'd9 && op == 5'd17)));

  // R12
  wr_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (op == 5'd1 || op == 5'd2 || op == 5'd5 || op == 5'd7 || op == 5'd8 ||
               op == 5'd13 || op == 5'd14 || op == 5'd15));
endmodule

bind insn_fmt_decoder ifd_checker u_ifd_checker (.*);

// File: tb/tb_insn_fmt_decoder.sv
module tb_insn_fmt_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        out_valid;
  logic [1:0]  form;
  logic [4:0]  op;
  logic [3:0]  func;
  logic [1:0]  mem_size;
  logic [3:0]  reg_a, reg_b;
  logic [7:0]  imm8;
  logic [10:0] br_off;
  logic [3:0]  cond;
  logic [2:0]  len_bytes;
  logic        illegal, wr_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  insn_fmt_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .out_valid(out_valid), .form(form), .op(op), .func(func), .mem_size(mem_size),
    .reg_a(reg_a), .reg_b(reg_b), .imm8(imm8), .br_off(br_off), .cond(cond),
    .len_bytes(len_bytes), .illegal(illegal), .wr_en(wr_en)
  );

  // {insn, form, op, func, size, ra, rb, imm, len, illegal, wr}
  localparam int NV = 38;
  localparam logic [49:0] VEC [0:NV-1] = '{
    {16'h0000, 2'd0, 5'd0,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h0135, 2'd0, 5'd1,  4'd0,  2'd0, 4'h3, 4'h5, 8'h00, 3'd6, 1'b0, 1'b1},
    {16'h0212, 2'd0, 5'd2,  4'd0,  2'd0, 4'h1, 4'h2, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h0300, 2'd0, 5'd3,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0},
    {16'h0400, 2'd0, 5'd4,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h05AB, 2'd0, 5'd5,  4'd1,  2'd0, 4'hA, 4'hB, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h0612, 2'd0, 5'd6,  4'd0,  2'd0, 4'h1, 4'h2, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h0713, 2'd0, 5'd7,  4'd0,  2'd0, 4'h1, 4'h3, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h0840, 2'd0, 5'd8,  4'd0,  2'd0, 4'h4, 4'h0, 8'h00, 3'd6, 1'b0, 1'b1},
    {16'h0950, 2'd0, 5'd9,  4'd0,  2'd0, 4'h5, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0},
    {16'h0A23, 2'd0, 5'd8,  4'd0,  2'd0, 4'h2, 4'h3, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h0D67, 2'd0, 5'd9,  4'd0,  2'd0, 4'h6, 4'h7, 8'h00, 3'd6, 1'b0, 1'b0},
    {16'h0E45, 2'd0, 5'd10, 4'd0,  2'd0, 4'h4, 4'h5, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h0F00, 2'd0, 5'd0,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0},
    {16'h1812, 2'd0, 5'd0,  4'd0,  2'd0, 4'h1, 4'h2, 8'h00, 3'd2, 1'b1, 1'b0},
    {16'h1930, 2'd0, 5'd3,  4'd0,  2'd0, 4'h3, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h1A00, 2'd0, 5'd11, 4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0},
    {16'h1B70, 2'd0, 5'd1,  4'd0,  2'd1, 4'h7, 4'h0, 8'h00, 3'd6, 1'b0, 1'b1},
    {16'h1E89, 2'd0, 5'd9,  4'd0,  2'd1, 4'h8, 4'h9, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h2290, 2'd0, 5'd8,  4'd0,  2'd2, 4'h9, 4'h0, 8'h00, 3'd6, 1'b0, 1'b1},
    {16'h2534, 2'd0, 5'd11, 4'd0,  2'd0, 4'h3, 4'h4, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h2712, 2'd0, 5'd5,  4'd7,  2'd0, 4'h1, 4'h2, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h2D12, 2'd0, 5'd5,  4'd8,  2'd0, 4'h1, 4'h2, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h2AC3, 2'd0, 5'd5,  4'd9,  2'd0, 4'hC, 4'h3, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h2F45, 2'd0, 5'd5,  4'd11, 2'd0, 4'h4, 4'h5, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h3245, 2'd0, 5'd5,  4'd13, 2'd0, 4'h4, 4'h5, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h3400, 2'd0, 5'd5,  4'd15, 2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b1},
    {16'h3000, 2'd0, 5'd12, 4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd6, 1'b0, 1'b0},
    {16'h3500, 2'd0, 5'd12, 4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'h38AB, 2'd0, 5'd8,  4'd0,  2'd2, 4'hA, 4'hB, 8'h00, 3'd6, 1'b0, 1'b1},
    {16'h3A00, 2'd0, 5'd0,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0},
    {16'h83F0, 2'd1, 5'd13, 4'd1,  2'd0, 4'h3, 4'h0, 8'hF0, 3'd2, 1'b0, 1'b1},
    {16'h9A05, 2'd1, 5'd14, 4'd2,  2'd0, 4'hA, 4'h0, 8'h05, 3'd2, 1'b0, 1'b1},
    {16'hA2FF, 2'd1, 5'd15, 4'd0,  2'd0, 4'h2, 4'h0, 8'hFF, 3'd2, 1'b0, 1'b1},
    {16'hB107, 2'd1, 5'd16, 4'd0,  2'd0, 4'h1, 4'h0, 8'h07, 3'd2, 1'b0, 1'b0},
    {16'hC000, 2'd2, 5'd17, 4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'hE7FF, 2'd2, 5'd17, 4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b0, 1'b0},
    {16'hE800, 2'd2, 5'd0,  4'd0,  2'd0, 4'h0, 4'h0, 8'h00, 3'd2, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic present(input logic [15:0] w);
    insn = w;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  function automatic bit exp_long(input int c);
    return c inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D, 8'h1A, 8'h1B,
                     8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30, [8'h36:8'h39]};
  endfunction

  function automatic bit exp_legal(input int c);
    return (c <= 8'h0E) || (c >= 8'h19 && c <= 8'h39);
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: everything zero in reset
    chk("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "op", {27'd0, op}, 32'd0);
    chk("R1", "len", {29'd0, len_bytes}, 32'd0);
    chk("R1", "fields", {reg_a, reg_b, imm8, br_off, cond, illegal, wr_en, form, func, mem_size}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R3 R4 R5 R7 R8 R9 R10 R11 R12 R13
    for (int i = 0; i < NV; i++) begin
      present(VEC[i][49:34]);
      chk("R2", "out_valid", {31'd0, out_valid}, 32'd1);
      chk("R3", "form", {30'd0, form}, {30'd0, VEC[i][33:32]});
      chk("R9", "op", {27'd0, op}, {27'd0, VEC[i][31:27]});
      chk("R10", "func", {28'd0, func}, {28'd0, VEC[i][26:23]});
      chk("R11", "mem_size", {30'd0, mem_size}, {30'd0, VEC[i][22:21]});
      chk("R4", "reg_a", {28'd0, reg_a}, {28'd0, VEC[i][20:17]});
      chk("R4", "reg_b", {28'd0, reg_b}, {28'd0, VEC[i][16:13]});
      chk("R5", "imm8", {24'd0, imm8}, {24'd0, VEC[i][12:5]});
      chk("R6", "len", {29'd0, len_bytes}, {29'd0, VEC[i][4:2]});
      chk("R7", "illegal", {31'd0, illegal}, {31'd0, VEC[i][1]});
      chk("R12", "wr_en", {31'd0, wr_en}, {31'd0, VEC[i][0]});
    end

    // Sweep of all primary opcodes: R6 R7 R8
    for (int c = 0; c < 128; c++) begin
      present({c[7:0], 8'h5A});
      chk("R6", $sformatf("len op=%02h", c), {29'd0, len_bytes}, exp_long(c) ? 32'd6 : 32'd2);
      chk("R7", $sformatf("illegal op=%02h", c), {31'd0, illegal}, {31'd0, !exp_legal(c)});
      if (!exp_legal(c)) begin
        chk("R8", $sformatf("squash op=%02h", c), {26'd0, op, wr_en}, 32'd0);
      end
    end

    // R13: branch condition and offsets at the extremes
    present(16'hC1FF);
    chk("R13", "cond max+", {28'd0, cond}, 32'd0);
    chk("R13", "br_off max+", {21'd0, br_off}, {21'd0, 11'h3FE});
    present(16'hC200);
    chk("R13", "br_off min", {21'd0, br_off}, {21'd0, 11'h400});
    present(16'hC7FF);
    chk("R13", "cond 1", {28'd0, cond}, 32'd1);
    chk("R13", "br_off -2", {21'd0, br_off}, {21'd0, 11'h7FE});
    present(16'hE400);
    chk("R13", "cond 9 legal", {31'd0, illegal}, 32'd0);
    chk("R13", "cond 9", {28'd0, cond}, 32'd9);
    present(16'hFFFF);
    chk("R13", "cond 15 illegal", {31'd0, illegal}, 32'd1);
    chk("R8", "cond 15 op", {27'd0, op}, 32'd0);
    chk("R4", "primary offset zero", 32'd0, 32'd0);
    present(16'h05AB);
    chk("R4", "primary br_off", {21'd0, br_off}, 32'd0);
    chk("R4", "primary cond", {28'd0, cond}, 32'd0);

    // R2: an idle word is ignored and fields hold
    insn = 16'h0E00;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2", "idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R2", "idle op held", {27'd0, op}, 32'd5);
    chk("R2", "idle reg_a held", {28'd0, reg_a}, 32'hA);
    @(negedge clk);
    chk("R2", "idle func held", {28'd0, func}, 32'd1);

    // R1: reset mid-run clears outputs
    present(16'h0135);
    rst_n = 1'b0;
    #1;
    chk("R1", "reset clears op", {27'd0, op}, 32'd0);
    chk("R1", "reset clears len", {29'd0, len_bytes}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule